// File: doc/BRIEF.md
# Transition-Compressed Timing Capture

This block watches a parallel input bus on every sample clock and writes into an acquisition memory only when the bus changes. Each write is a pair of words. One word holds the new bus value and the other holds the number of sample clocks since the previous recorded pair. A quiet bus therefore uses no memory, and memory use grows with bus activity rather than with elapsed time. The timing resolution is one sample clock period.

Capture is gated by a run level. The first sample taken after run goes high is always recorded with an elapsed count of zero, so the trace has a fixed starting point. The elapsed counter has a fixed width. If the bus stays still until the counter reaches its largest value, the block writes a filler pair that repeats the unchanged value, so a long idle gap can still be measured. When the pair written at the last even address fills memory, the block raises a sticky full flag and stops writing.

Top module: `tcc_capture`

## Requirements
- R1: The first sampling edge with run high (after reset, or after run was low) records a pair whose value is the sampled bus and whose count is 0.
- R2: While capturing, an edge whose sample differs from the sample at the previous capturing edge records a pair carrying the new sample value.
- R3: The count of a recorded pair equals the number of sample clocks between the edge that records it and the edge that recorded the previous pair.
- R4: While capturing, an edge whose sample equals the previous sample writes nothing, unless R5 applies.
- R5: With a counter of CNT_W bits, if 2^CNT_W-1 clocks pass since the last pair with no change, a pair is recorded with the unchanged value and count 2^CNT_W-1, and counting starts again from that edge.
- R6: Each pair is presented on one write strobe, with wr_addr even. The value goes to wr_addr and the count to wr_addr+1. Pairs take the addresses 0, 2, 4 and upward in recording order.
- R7: The pair written at address DEPTH-2 raises full in the same cycle as its strobe. full stays high until reset, and no write occurs while it is high.
- R8: While run is low nothing is written, and the next capture starts with a new reference pair as in R1.
- R9: After reset, wr_en is 0, full is 0 and wr_addr is 0.
- R10: The write strobe for a pair appears in the cycle after the sampling edge that records it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Capture enable level |
| sample_in | input | DATA_W | Bus under observation |
| wr_en | output | 1 | Write strobe for one pair |
| wr_addr | output | log2(DEPTH) | Even address of the value word; the count word goes to the next address |
| wr_value | output | DATA_W | Sample value word |
| wr_count | output | CNT_W | Elapsed-clock count word |
| full | output | 1 | Sticky flag: memory holds its last pair |

## Verification
The assertions check the cycle-level rules on every clock. They confirm that a reference write carries count zero, that a static bus or a low run level leaves the strobe idle, that a saturated counter forces a filler write of the maximum count, that consecutive strobes step the address by two, and that full rises only together with the last-address write and silences the port afterwards. Whether the recorded counts add up to the true gaps across a whole trace, with transitions landing exactly on the saturation boundary or run pauses in mid-stream, can only be shown by the bench. It rebuilds the expected pair list from the edge history it drove and compares it with the collected memory contents.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  // Reason a pair is recorded on a sampling edge.
  typedef enum logic [1:0] {
    REC_NONE   = 2'd0,
    REC_FIRST  = 2'd1,
    REC_CHANGE = 2'd2,
    REC_SAT    = 2'd3
  } rec_kind_e;

  // Decide what a sampling edge records. A change wins over saturation
  // because it carries the same count and also the new value.
  function automatic rec_kind_e classify(
    input logic cap_en,
    input logic armed,
    input logic changed,
    input logic at_max
  );
    if (!cap_en)      return REC_NONE;
    if (!armed)       return REC_FIRST;
    if (changed)      return REC_CHANGE;
    if (at_max)       return REC_SAT;
    return REC_NONE;
  endfunction

endpackage

// File: rtl/tcc_change_detect.sv
module tcc_change_detect #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] sample_in,
  output logic              armed,
  output logic              changed,
  output logic [DATA_W-1:0] prev_q
);

  logic armed_q;

  // Set once a capturing edge has happened; cleared by any non-capturing edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= cap_en;
    end
  end

  // The last sample taken while capturing.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (cap_en) begin
      prev_q <= sample_in;
    end
  end

  assign armed   = armed_q;
  assign changed = (sample_in != prev_q);

  // R8
  stop_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> !armed);

endmodule

// File: rtl/tcc_elapsed_counter.sv
module tcc_elapsed_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             rec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_max
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // Clocks since the last recorded pair, as seen at the next edge.
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic             en,
    input logic             did_rec
  );
    if (!en)     return '0;
    if (did_rec) return CNT_ONE;
    return cur + CNT_ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= next_count(cnt_q, cap_en, rec);
    end
  end

  assign at_max = (cnt_q == CNT_MAX);

  // R3
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (!cap_en || cnt_q != '0));

  // R5
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && at_max) |=> (cnt_q == CNT_ONE || !$past(cap_en)));

endmodule

// File: rtl/tcc_write_ctrl.sv
module tcc_write_ctrl
  import tcc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rec_kind_e         kind,
  input  logic [DATA_W-1:0] rec_value,
  input  logic [CNT_W-1:0]  rec_count,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_value,
  output logic [CNT_W-1:0]  wr_count,
  output logic              full
);

  localparam logic [ADDR_W-1:0] LAST_PAIR = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] PAIR_STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] ptr_q;
  logic              do_write;

  function automatic logic is_last(input logic [ADDR_W-1:0] p);
    return p == LAST_PAIR;
  endfunction

  function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p);
    return p + PAIR_STEP;
  endfunction

  assign do_write = (kind != REC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_value <= '0;
      wr_count <= '0;
      full     <= 1'b0;
    end else begin
      wr_en <= do_write;
      if (do_write) begin
        wr_addr  <= ptr_q;
        wr_value <= rec_value;
        wr_count <= rec_count;
        ptr_q    <= step_ptr(ptr_q);
        if (is_last(ptr_q)) begin
          full <= 1'b1;
        end
      end
    end
  end

  // R7
  full_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(full) |-> (!wr_en && full));

  // R7
  last_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> (wr_en && wr_addr == LAST_PAIR));

  // R6
  pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + PAIR_STEP)));

endmodule

// File: rtl/tcc_capture.sv
module tcc_capture
  import tcc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DATA_W-1:0] sample_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_value,
  output logic [CNT_W-1:0]  wr_count,
  output logic              full
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Named internal events for the checks below.
  logic              cap_en;
  logic              armed;
  logic              changed;
  logic              at_max;
  logic              rec_any;
  logic [DATA_W-1:0] prev_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  rec_count;
  rec_kind_e         kind;

  assign cap_en    = run && !full;
  assign kind      = classify(cap_en, armed, changed, at_max);
  assign rec_any   = (kind != REC_NONE);
  assign rec_count = (kind == REC_FIRST) ? '0 : cnt_q;

  tcc_change_detect #(.DATA_W(DATA_W)) detect_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .sample_in (sample_in),
    .armed     (armed),
    .changed   (changed),
    .prev_q    (prev_q)
  );

  tcc_elapsed_counter #(.CNT_W(CNT_W)) counter_u (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .rec    (rec_any),
    .cnt_q  (cnt_q),
    .at_max (at_max)
  );

  tcc_write_ctrl #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) wctrl_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (kind),
    .rec_value (sample_in),
    .rec_count (rec_count),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_value  (wr_value),
    .wr_count  (wr_count),
    .full      (full)
  );

  // R1
  first_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !armed) |=> (wr_en && wr_count == '0));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && armed && !changed && !at_max) |=> !wr_en);

  // R5
  sat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && armed && !changed && at_max) |=> (wr_en && wr_count == CNT_MAX && wr_value == $past(prev_q)));

  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !wr_en);

  // R10
  change_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && armed && changed) |=> (wr_en && wr_value == $past(sample_in)));

endmodule

// File: tb/tcc_capture_tb.sv
module tcc_capture_tb_top;

  localparam int DATA_W  = 8;
  localparam int CNT_W   = 6;
  localparam int DEPTH   = 64;
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int PAIRS   = DEPTH / 2;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int MAX_E   = 512;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              run = 1'b0;
  logic [DATA_W-1:0] sample_in = '0;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_value;
  logic [CNT_W-1:0]  wr_count;
  logic              full;

  always #5 clk = ~clk;

  tcc_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .sample_in(sample_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_value(wr_value),
    .wr_count(wr_count), .full(full)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic              stim_run [MAX_E];
  logic [DATA_W-1:0] stim_val [MAX_E];
  int                got_val  [PAIRS];
  int                got_cnt  [PAIRS];
  int                got_addr [PAIRS];
  int                n_got;
  int                exp_val  [PAIRS];
  int                exp_cnt  [PAIRS];
  int                n_exp;
  bit                exp_full;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input logic r, input logic [DATA_W-1:0] v);
    @(negedge clk);
    if (wr_en) begin
      if (n_got < PAIRS) begin
        got_val[n_got]  = int'(wr_value);
        got_cnt[n_got]  = int'(wr_count);
        got_addr[n_got] = int'(wr_addr);
      end
      n_got++;
    end
    run = r;
    sample_in = v;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    run = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_en == 1'b0, "R9 wr_en", int'(wr_en), 0);
    check(full == 1'b0, "R9 full", int'(full), 0);
    check(wr_addr == '0, "R9 wr_addr", int'(wr_addr), 0);
  endtask

  task automatic push_exp(input int v, input int c);
    if (n_exp < PAIRS) begin
      exp_val[n_exp] = v;
      exp_cnt[n_exp] = c;
      n_exp++;
      if (n_exp == PAIRS) exp_full = 1'b1;
    end
  endtask

  // Expected trace from edge history: counts are edge-index distances.
  task automatic build_expected(input int n);
    int last_e = 0;
    bit live = 0;
    int prev = 0;
    n_exp = 0;
    exp_full = 1'b0;
    for (int e = 0; e < n; e++) begin
      if (stim_run[e] && !exp_full) begin
        if (!live) begin
          push_exp(int'(stim_val[e]), 0);
          live = 1; last_e = e; prev = int'(stim_val[e]);
        end else if (int'(stim_val[e]) != prev) begin
          push_exp(int'(stim_val[e]), e - last_e);
          last_e = e; prev = int'(stim_val[e]);
        end else if (e - last_e == CNT_MAX) begin
          push_exp(prev, CNT_MAX);
          last_e = e;
        end
      end else begin
        live = 0;
      end
    end
  endtask

  task automatic run_scen(input int n, input string tag);
    do_reset();
    n_got = 0;
    for (int e = 0; e < n; e++) step(stim_run[e], stim_val[e]);
    repeat (3) step(1'b0, '0);
    build_expected(n);
    check(n_got == n_exp, {tag, " pair total"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got && i < PAIRS; i++) begin
      check(got_val[i] == exp_val[i], {tag, " R2 value"}, got_val[i], exp_val[i]);
      if (exp_cnt[i] == 0)
        check(got_cnt[i] == 0, {tag, " R1 ref count"}, got_cnt[i], 0);
      else if (exp_cnt[i] == CNT_MAX)
        check(got_cnt[i] == exp_cnt[i], {tag, " R5 count"}, got_cnt[i], exp_cnt[i]);
      else
        check(got_cnt[i] == exp_cnt[i], {tag, " R3 count"}, got_cnt[i], exp_cnt[i]);
      check(got_addr[i] == 2 * i, {tag, " R6 addr"}, got_addr[i], 2 * i);
    end
    check(full == exp_full, {tag, " R7 full"}, int'(full), int'(exp_full));
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R4 R5: static bus, saturation fillers only.
    for (int e = 0; e < 200; e++) begin stim_run[e] = 1'b1; stim_val[e] = 8'h5A; end
    run_scen(200, "R4");

    // R8: run low with a busy bus writes nothing.
    for (int e = 0; e < 50; e++) begin stim_run[e] = 1'b0; stim_val[e] = 8'($urandom); end
    run_scen(50, "R8");

    // R2 R3: sparse random transitions.
    stim_val[0] = 8'h11;
    for (int e = 0; e < 200; e++) begin
      stim_run[e] = 1'b1;
      if (e > 0) stim_val[e] = ($urandom_range(0, 7) == 0) ? 8'($urandom) : stim_val[e-1];
    end
    run_scen(200, "R2");

    // R7 R10: change every clock until memory fills.
    for (int e = 0; e < 60; e++) begin stim_run[e] = 1'b1; stim_val[e] = 8'(e * 37 + 1); end
    run_scen(60, "R7");

    // R8: pause and resume, new reference after resume.
    stim_val[0] = 8'h33;
    for (int e = 0; e < 70; e++) begin
      stim_run[e] = !(e >= 30 && e < 40);
      if (e > 0) stim_val[e] = ($urandom_range(0, 3) == 0) ? 8'($urandom) : stim_val[e-1];
    end
    run_scen(70, "R8");

    // R5: change landing exactly on the saturation edge, then idle.
    for (int e = 0; e < 150; e++) begin
      stim_run[e] = 1'b1;
      stim_val[e] = (e < CNT_MAX) ? 8'hA0 : 8'hA1;
    end
    run_scen(150, "R5");

    // R3 R8: random run gaps and dense random data.
    stim_val[0] = 8'h00;
    for (int e = 0; e < 400; e++) begin
      stim_run[e] = ($urandom_range(0, 15) != 0);
      if (e > 0) stim_val[e] = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(0, 3)) : stim_val[e-1];
    end
    run_scen(400, "R3");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule